// File: doc/BRIEF.md
# Dual-Processor Mailbox Messaging Unit

This block lets two processors that share a clock, called side A and side B, pass words and signals to each other. Each side has its own 32-bit register port. The port gives the side four outgoing message slots, a read-only window onto the four slots the other side sends, a status word and a control word. A word written into an outgoing slot of one side is seen at once in the matching incoming slot of the other side. Each channel keeps a single full/empty handshake. The sender sees its slot as empty again only after the receiver has read the word.

The unit also carries signals between the sides. Three flag bits are copied across with a one-cycle transfer window, and a pending bit shows while the copy is in flight. Four general interrupt requests per direction each become a sticky pending bit on the far side, and software clears that bit by writing one to it. Each side has a single interrupt line, formed from its enabled empty, full and pending conditions. Side A alone controls side B's hardware reset. While side B is held in reset, side B's register port is dead. When the reset is released, a release-pending bit is set on side A and, if enabled, side A's general interrupt 3 is raised. Side A can also clear the whole unit back to its reset state by setting a self-clearing bit.

Register word index is `addr[5:2]`: 0-3 outgoing slots (read back what was written), 4-7 incoming slots, 8 status, 9 control, all others read 0. Status layout: [2:0] flags from the far side, [4] any event pending, [7] side B in reset (A only), [8] own flag copy in flight, [9] release pending (A only), [23:20] outgoing slot n empty, [27:24] incoming slot n full, [31:28] general interrupt n pending. Control layout: [2:0] outgoing flags, [4] hold side B in reset (A only), [5] unit clear (A only, reads 0), [6] release interrupt enable (A only), [19:16] general interrupt request to the far side, [23:20] empty interrupt enable, [27:24] full interrupt enable, [31:28] general interrupt enable.

Top module: `mbx_top`

## Requirements
- R1: After reset every status word reads 0x00F00000 (all four empty bits [23:20] set), every control word and slot reads 0, both interrupt lines and the side B reset output are 0.
- R2: A write to outgoing slot n (index n) of one side, issued in the cycle before edge t, makes the word readable at the other side's index 4+n from edge t on; it also clears the sender's status bit 20+n and sets the receiver's status bit 24+n.
- R3: A write to an outgoing slot whose word has not yet been read is ignored: the stored word stays unchanged.
- R4: Reading incoming slot n while it is full clears the reader's status bit 24+n and sets the sender's status bit 20+n at the same edge.
- R5: Each interrupt line is registered and, one edge after the state, equals the OR over n of (empty n and control bit 20+n), (full n and control bit 24+n) and (pending n and control bit 28+n).
- R6: A control write loads flags [2:0] and sets status bit 8 for one cycle; at the next edge the flags appear in the far side's status bits [2:0] and bit 8 clears.
- R7: Control bits [19:16] set the far side's status bits [31:28] one edge after the write and clear themselves at that edge; writing 1 to a status bit in [31:28] clears it, writing 0 leaves it, and a set wins over a clear in the same cycle.
- R8: Side A control bit 4 drives the side B reset output directly from its register; side A status bit 7 follows it one edge later.
- R9: When side B's reset is released, side A status bit 9 is set; if side A control bit 6 is 1 at that moment, side A status bit 31 (general interrupt 3) is set too; writing 1 to status bit 9 clears it.
- R10: While the side B reset output is 1, side B writes and reads have no effect and side B's read data is 0.
- R11: A side A control write with bit 5 set returns the whole unit, both sides and all slots, to the reset state of R1 at that edge; bit 5 reads back 0.
- R12: Status bit 4 is 1 exactly when some incoming slot is full or some general interrupt is pending (on side A, also when bit 9 is set).
- R13: Read data is registered: a read issued before edge t returns the word at edge t, computed from the state before t; cycles without a read, and unmapped indices, return 0; outgoing slots and control read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Side A register write strobe |
| a_rd | input | 1 | Side A register read strobe |
| a_addr | input | 6 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after the read |
| a_irq | output | 1 | Side A interrupt line |
| b_wr | input | 1 | Side B register write strobe |
| b_rd | input | 1 | Side B register read strobe |
| b_addr | input | 6 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after the read |
| b_irq | output | 1 | Side B interrupt line |
| b_core_rst | output | 1 | Hardware reset to processor B |

## Verification
The assertions check several rules on every cycle. A full slot's word never changes. A general interrupt request always shows up as pending on the far side one cycle later. The reset-state bit tracks the reset output. Each fall of that bit leaves the release-pending bit set, and side B's read data stays zero while it is held in reset. Other behaviours appear only through the bench's scenarios, which a behavioural model compares on every clock: the exact status and control encodings, the flag transfer window, write-one-to-clear, ignored writes to full slots, the unit clear, and the interrupt enables.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // word indices (addr[5:2])
  localparam int unsigned IDX_RX_BASE = 4;
  localparam int unsigned IDX_STAT    = 8;
  localparam int unsigned IDX_CTRL    = 9;

  // status word fields
  localparam int unsigned ST_FLG_LSB  = 0;
  localparam int unsigned ST_EVT_BIT  = 4;
  localparam int unsigned ST_BRS_BIT  = 7;
  localparam int unsigned ST_FUP_BIT  = 8;
  localparam int unsigned ST_REL_BIT  = 9;
  localparam int unsigned ST_TE_LSB   = 20;
  localparam int unsigned ST_RF_LSB   = 24;
  localparam int unsigned ST_GIP_LSB  = 28;

  // control word fields
  localparam int unsigned CT_FLG_LSB  = 0;
  localparam int unsigned CT_HOLD_BIT = 4;
  localparam int unsigned CT_CLR_BIT  = 5;
  localparam int unsigned CT_RELE_BIT = 6;
  localparam int unsigned CT_GIR_LSB  = 16;
  localparam int unsigned CT_TIE_LSB  = 20;
  localparam int unsigned CT_RIE_LSB  = 24;
  localparam int unsigned CT_GIE_LSB  = 28;

  // general interrupt raised on side A by the side B release
  localparam int unsigned REL_GI_IDX  = 3;

  typedef enum logic [2:0] {
    SEL_TX, SEL_RX, SEL_STAT, SEL_CTRL, SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/mbx_chan_bank.sv
module mbx_chan_bank #(
  parameter int DW  = 32,
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    put,
  input  logic [IW-1:0]           put_idx,
  input  logic [DW-1:0]           put_data,
  input  logic                    take,
  input  logic [IW-1:0]           take_idx,
  output logic [NCH-1:0]          full,
  output logic [NCH-1:0][DW-1:0]  data
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic accept;
    assign accept = put && (put_idx == IW'(i)) && !full[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        full[i] <= 1'b0;
        data[i] <= '0;
      end else begin
        if (accept) begin
          full[i] <= 1'b1;
          data[i] <= put_data;
        end else if (take && (take_idx == IW'(i))) begin
          full[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/mbx_side.sv
module mbx_side
  import mbx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCH  = 4,
  parameter int NFLG = 3,
  parameter int NGI  = 4,
  parameter int AW   = 6,
  parameter bit IS_A = 1'b1,
  localparam int IW  = $clog2(NCH),
  localparam int RW  = AW - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_en,
  input  logic                    wr,
  input  logic                    rd,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic [DW-1:0]           rdata,
  output logic                    irq,
  input  logic [NCH-1:0]          tx_full,
  input  logic [NCH-1:0][DW-1:0]  tx_data,
  input  logic [NCH-1:0]          rx_full,
  input  logic [NCH-1:0][DW-1:0]  rx_data,
  output logic                    tx_put,
  output logic [IW-1:0]           tx_idx,
  output logic                    rx_take,
  output logic [IW-1:0]           rx_idx,
  input  logic [NFLG-1:0]         flag_in,
  output logic [NFLG-1:0]         flag_out,
  input  logic [NGI-1:0]          gi_in,
  output logic [NGI-1:0]          gi_req,
  output logic [NGI-1:0]          gi_pend,
  output logic                    hold_b,
  output logic                    b_in_rst,
  output logic                    rel_pend
);

  logic [RW-1:0] idx;
  logic          wr_ok, rd_ok, wr_ctl, wr_st;
  reg_sel_e      sel;

  assign idx    = addr[AW-1:2];
  assign wr_ok  = wr & acc_en;
  assign rd_ok  = rd & acc_en;
  assign wr_ctl = wr_ok && (idx == RW'(IDX_CTRL));
  assign wr_st  = wr_ok && (idx == RW'(IDX_STAT));

  always_comb begin
    if (idx < RW'(NCH))                                              sel = SEL_TX;
    else if (idx >= RW'(IDX_RX_BASE) && idx < RW'(IDX_RX_BASE + NCH)) sel = SEL_RX;
    else if (idx == RW'(IDX_STAT))                                   sel = SEL_STAT;
    else if (idx == RW'(IDX_CTRL))                                   sel = SEL_CTRL;
    else                                                             sel = SEL_NONE;
  end

  assign tx_put  = wr_ok && (sel == SEL_TX);
  assign tx_idx  = idx[IW-1:0];
  assign rx_take = rd_ok && (sel == SEL_RX);
  assign rx_idx  = IW'(idx - RW'(IDX_RX_BASE));

  // common control and signalling state
  logic [NFLG-1:0] cflag;
  logic            fup;
  logic [NCH-1:0]  tie, rie;
  logic [NGI-1:0]  gie;
  logic [NGI-1:0]  gip_clr, rel_gi;

  assign gip_clr = wr_st ? wdata[ST_GIP_LSB +: NGI] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cflag    <= '0;
      fup      <= 1'b0;
      flag_out <= '0;
      gi_req   <= '0;
      tie      <= '0;
      rie      <= '0;
      gie      <= '0;
      gi_pend  <= '0;
    end else begin
      if (wr_ctl) begin
        cflag  <= wdata[CT_FLG_LSB +: NFLG];
        fup    <= 1'b1;
        gi_req <= wdata[CT_GIR_LSB +: NGI];
        tie    <= wdata[CT_TIE_LSB +: NCH];
        rie    <= wdata[CT_RIE_LSB +: NCH];
        gie    <= wdata[CT_GIE_LSB +: NGI];
      end else begin
        gi_req <= '0;
        if (fup) begin
          flag_out <= cflag;
          fup      <= 1'b0;
        end
      end
      gi_pend <= (gi_pend & ~gip_clr) | gi_in | rel_gi;
    end
  end

  // reset control of the far side exists on side A only
  logic rel_en;
  if (IS_A) begin : g_rst_ctl
    logic hold_q, brs_q, rele_q, relp_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        hold_q <= 1'b0;
        brs_q  <= 1'b0;
        rele_q <= 1'b0;
        relp_q <= 1'b0;
      end else begin
        if (wr_ctl) begin
          hold_q <= wdata[CT_HOLD_BIT];
          rele_q <= wdata[CT_RELE_BIT];
        end
        brs_q  <= hold_q;
        relp_q <= (relp_q & ~(wr_st & wdata[ST_REL_BIT])) | (brs_q & ~hold_q);
      end
    end
    assign hold_b   = hold_q;
    assign b_in_rst = brs_q;
    assign rel_pend = relp_q;
    assign rel_en   = rele_q;
    always_comb begin
      rel_gi             = '0;
      rel_gi[REL_GI_IDX] = brs_q & ~hold_q & rele_q;
    end
  end else begin : g_no_rst_ctl
    assign hold_b   = 1'b0;
    assign b_in_rst = 1'b0;
    assign rel_pend = 1'b0;
    assign rel_en   = 1'b0;
    assign rel_gi   = '0;
  end

  // register words
  logic [DW-1:0] st_word, ct_word, rmux;

  always_comb begin
    st_word                          = '0;
    st_word[ST_FLG_LSB +: NFLG]      = flag_in;
    st_word[ST_FUP_BIT]              = fup;
    st_word[ST_TE_LSB +: NCH]        = ~tx_full;
    st_word[ST_RF_LSB +: NCH]        = rx_full;
    st_word[ST_GIP_LSB +: NGI]       = gi_pend;
    st_word[ST_BRS_BIT]              = b_in_rst;
    st_word[ST_REL_BIT]              = rel_pend;
    st_word[ST_EVT_BIT]              = (|rx_full) | (|gi_pend) | rel_pend;
  end

  always_comb begin
    ct_word                      = '0;
    ct_word[CT_FLG_LSB +: NFLG]  = cflag;
    ct_word[CT_HOLD_BIT]         = hold_b;
    ct_word[CT_RELE_BIT]         = rel_en;
    ct_word[CT_GIR_LSB +: NGI]   = gi_req;
    ct_word[CT_TIE_LSB +: NCH]   = tie;
    ct_word[CT_RIE_LSB +: NCH]   = rie;
    ct_word[CT_GIE_LSB +: NGI]   = gie;
  end

  always_comb begin
    unique case (sel)
      SEL_TX:   rmux = tx_data[tx_idx];
      SEL_RX:   rmux = rx_data[rx_idx];
      SEL_STAT: rmux = st_word;
      SEL_CTRL: rmux = ct_word;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      rdata <= rd_ok ? rmux : '0;
      irq   <= (|(~tx_full & tie)) | (|(rx_full & rie)) | (|(gi_pend & gie));
    end
  end

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata};

endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NCH  = 4,
  parameter int NFLG = 3,
  parameter int NGI  = 4,
  parameter int AW   = 6,
  localparam int IW  = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq,
  output logic          b_core_rst
);

  // unit clear: side A control write with the clear bit, applied at this edge
  logic unit_rst;
  assign unit_rst = rst | (a_wr && (a_addr[AW-1:2] == (AW-2)'(IDX_CTRL)) && a_wdata[CT_CLR_BIT]);

  logic [NCH-1:0]         ab_full, ba_full;
  logic [NCH-1:0][DW-1:0] ab_data, ba_data;
  logic                   a_put, b_put, a_take, b_take;
  logic [IW-1:0]          a_put_idx, b_put_idx, a_take_idx, b_take_idx;
  logic [NFLG-1:0]        a_flag, b_flag;
  logic [NGI-1:0]         a_gir, b_gir, a_gip, b_gip;
  logic                   a_hold, a_brs, a_relp;
  logic                   b_hold_nc, b_brs_nc, b_relp_nc;

  mbx_chan_bank #(.DW(DW), .NCH(NCH)) u_ab (
    .clk(clk), .rst(unit_rst),
    .put(a_put), .put_idx(a_put_idx), .put_data(a_wdata),
    .take(b_take), .take_idx(b_take_idx),
    .full(ab_full), .data(ab_data)
  );

  mbx_chan_bank #(.DW(DW), .NCH(NCH)) u_ba (
    .clk(clk), .rst(unit_rst),
    .put(b_put), .put_idx(b_put_idx), .put_data(b_wdata),
    .take(a_take), .take_idx(a_take_idx),
    .full(ba_full), .data(ba_data)
  );

  mbx_side #(.DW(DW), .NCH(NCH), .NFLG(NFLG), .NGI(NGI), .AW(AW), .IS_A(1'b1)) u_sa (
    .clk(clk), .rst(unit_rst), .acc_en(1'b1),
    .wr(a_wr), .rd(a_rd), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .irq(a_irq),
    .tx_full(ab_full), .tx_data(ab_data), .rx_full(ba_full), .rx_data(ba_data),
    .tx_put(a_put), .tx_idx(a_put_idx), .rx_take(a_take), .rx_idx(a_take_idx),
    .flag_in(b_flag), .flag_out(a_flag),
    .gi_in(b_gir), .gi_req(a_gir), .gi_pend(a_gip),
    .hold_b(a_hold), .b_in_rst(a_brs), .rel_pend(a_relp)
  );

  mbx_side #(.DW(DW), .NCH(NCH), .NFLG(NFLG), .NGI(NGI), .AW(AW), .IS_A(1'b0)) u_sb (
    .clk(clk), .rst(unit_rst), .acc_en(~a_hold),
    .wr(b_wr), .rd(b_rd), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .irq(b_irq),
    .tx_full(ba_full), .tx_data(ba_data), .rx_full(ab_full), .rx_data(ab_data),
    .tx_put(b_put), .tx_idx(b_put_idx), .rx_take(b_take), .rx_idx(b_take_idx),
    .flag_in(a_flag), .flag_out(b_flag),
    .gi_in(a_gir), .gi_req(b_gir), .gi_pend(b_gip),
    .hold_b(b_hold_nc), .b_in_rst(b_brs_nc), .rel_pend(b_relp_nc)
  );

  assign b_core_rst = a_hold;

  logic unused_b_ctl;
  assign unused_b_ctl = b_hold_nc ^ b_brs_nc ^ b_relp_nc;

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int DW  = 32,
  parameter int NCH = 4,
  parameter int NGI = 4
) (
  input logic                   clk,
  input logic                   unit_rst,
  input logic [NCH-1:0]         ab_full,
  input logic [NCH-1:0][DW-1:0] ab_data,
  input logic [NCH-1:0]         ba_full,
  input logic [NCH-1:0][DW-1:0] ba_data,
  input logic [NGI-1:0]         a_gir,
  input logic [NGI-1:0]         b_gir,
  input logic [NGI-1:0]         a_gip,
  input logic [NGI-1:0]         b_gip,
  input logic                   a_brs,
  input logic                   a_relp,
  input logic                   b_core_rst,
  input logic [DW-1:0]          b_rdata
);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    // R3
    ab_word_hold_chk: assert property (@(posedge clk) disable iff (unit_rst)
      ab_full[n] |=> (!ab_full[n] || $stable(ab_data[n])));
    // R3
    ba_word_hold_chk: assert property (@(posedge clk) disable iff (unit_rst)
      ba_full[n] |=> (!ba_full[n] || $stable(ba_data[n])));
  end

  for (genvar g = 0; g < NGI; g++) begin : g_gi
    // R7
    a_to_b_gi_chk: assert property (@(posedge clk) disable iff (unit_rst)
      a_gir[g] |=> b_gip[g]);
    // R7
    b_to_a_gi_chk: assert property (@(posedge clk) disable iff (unit_rst)
      b_gir[g] |=> a_gip[g]);
  end

  // R8
  brs_follow_chk: assert property (@(posedge clk) disable iff (unit_rst)
    b_core_rst |=> a_brs);

  // R9
  release_pend_chk: assert property (@(posedge clk) disable iff (unit_rst)
    (!$past(unit_rst) && $fell(a_brs)) |-> a_relp);

  // R10
  b_dead_port_chk: assert property (@(posedge clk) disable iff (unit_rst)
    b_core_rst |=> (b_rdata == '0));

endmodule

bind mbx_top mbx_chk #(.DW(DW), .NCH(NCH), .NGI(NGI)) u_chk (
  .clk(clk), .unit_rst(unit_rst),
  .ab_full(ab_full), .ab_data(ab_data), .ba_full(ba_full), .ba_data(ba_data),
  .a_gir(a_gir), .b_gir(b_gir), .a_gip(a_gip), .b_gip(b_gip),
  .a_brs(a_brs), .a_relp(a_relp), .b_core_rst(b_core_rst), .b_rdata(b_rdata)
);

// File: tb/mbx_top_test.sv
module mbx_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [5:0]  a_addr = '0, b_addr = '0;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq, b_core_rst;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_top uut (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_irq(b_irq),
    .b_core_rst(b_core_rst)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done  = 0;
  string phase = "R1";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model (index 0 = side A, 1 = side B) ----
  logic [31:0] m_data [2][4];
  bit          m_full [2][4];
  bit [2:0]    m_cf [2], m_fo [2];
  bit          m_fup [2];
  bit [3:0]    m_gir [2], m_gip [2], m_tie [2], m_rie [2], m_gie [2];
  bit          m_bhr, m_brs, m_brdie, m_brdip;
  logic [31:0] m_rd [2];
  bit          m_irq [2];

  function automatic logic [31:0] m_status(int s);
    logic [31:0] o = '0;
    bit any = 0;
    o[2:0] = m_fo[1-s];
    o[8]   = m_fup[s];
    for (int n = 0; n < 4; n++) begin
      o[20+n] = !m_full[s][n];
      o[24+n] = m_full[1-s][n];
      o[28+n] = m_gip[s][n];
      if (m_full[1-s][n] || m_gip[s][n]) any = 1;
    end
    if (s == 0) begin
      o[7] = m_brs;
      o[9] = m_brdip;
      if (m_brdip) any = 1;
    end
    o[4] = any;
    return o;
  endfunction

  function automatic logic [31:0] m_ctrl(int s);
    logic [31:0] o = '0;
    o[2:0]   = m_cf[s];
    o[19:16] = m_gir[s];
    o[23:20] = m_tie[s];
    o[27:24] = m_rie[s];
    o[31:28] = m_gie[s];
    if (s == 0) begin
      o[4] = m_bhr;
      o[6] = m_brdie;
    end
    return o;
  endfunction

  function automatic logic [31:0] m_read(int s, logic [3:0] ix);
    if (ix < 4)       return m_data[s][ix[1:0]];
    else if (ix < 8)  return m_data[1-s][ix[1:0]];
    else if (ix == 8) return m_status(s);
    else if (ix == 9) return m_ctrl(s);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst || (a_wr && a_addr[5:2] == 4'd9 && a_wdata[5])) begin
      for (int s = 0; s < 2; s++) begin
        for (int n = 0; n < 4; n++) begin
          m_data[s][n] <= '0;
          m_full[s][n] <= 0;
        end
        m_cf[s] <= 0; m_fo[s] <= 0; m_fup[s] <= 0; m_gir[s] <= 0; m_gip[s] <= 0;
        m_tie[s] <= 0; m_rie[s] <= 0; m_gie[s] <= 0; m_rd[s] <= '0; m_irq[s] <= 0;
      end
      m_bhr <= 0; m_brs <= 0; m_brdie <= 0; m_brdip <= 0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        bit w, r, en, ti;
        logic [3:0] ix;
        logic [31:0] d;
        bit [3:0] clr, rel;
        en = (s == 0) ? 1'b1 : !m_bhr;
        w  = en && ((s == 0) ? a_wr : b_wr);
        r  = en && ((s == 0) ? a_rd : b_rd);
        ix = (s == 0) ? a_addr[5:2] : b_addr[5:2];
        d  = (s == 0) ? a_wdata : b_wdata;
        m_rd[s] <= r ? m_read(s, ix) : 32'h0;
        ti = 0;
        for (int n = 0; n < 4; n++)
          if ((!m_full[s][n] && m_tie[s][n]) || (m_full[1-s][n] && m_rie[s][n]) ||
              (m_gip[s][n] && m_gie[s][n])) ti = 1;
        m_irq[s] <= ti;
        if (w && ix < 4 && !m_full[s][ix[1:0]]) begin
          m_data[s][ix[1:0]] <= d;
          m_full[s][ix[1:0]] <= 1;
        end
        if (r && ix >= 4 && ix < 8 && m_full[1-s][ix[1:0]]) m_full[1-s][ix[1:0]] <= 0;
        if (w && ix == 9) begin
          m_cf[s] <= d[2:0]; m_fup[s] <= 1; m_gir[s] <= d[19:16];
          m_tie[s] <= d[23:20]; m_rie[s] <= d[27:24]; m_gie[s] <= d[31:28];
        end else begin
          m_gir[s] <= 0;
          if (m_fup[s]) begin
            m_fo[s]  <= m_cf[s];
            m_fup[s] <= 0;
          end
        end
        clr = (w && ix == 8) ? d[31:28] : 4'h0;
        rel = (s == 0 && m_brs && !m_bhr && m_brdie) ? 4'b1000 : 4'b0000;
        m_gip[s] <= (m_gip[s] & ~clr) | m_gir[1-s] | rel;
        if (s == 0) begin
          if (w && ix == 9) begin
            m_bhr   <= d[4];
            m_brdie <= d[6];
          end
          m_brs   <= m_bhr;
          m_brdip <= (m_brdip && !(w && ix == 8 && d[9])) || (m_brs && !m_bhr);
        end
      end
    end
  end

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done)
      check({phase, " model"}, {a_rdata[31:0] ^ b_rdata[31:0], 29'h0, a_irq, b_irq, b_core_rst},
            {m_rd[0] ^ m_rd[1], 29'h0, m_irq[0], m_irq[1], m_bhr});
    if (!rst && !done && (a_rdata !== m_rd[0] || b_rdata !== m_rd[1]))
      check({phase, " model rdata"}, a_rdata, m_rd[0] ^ 32'h0 ^ ((b_rdata !== m_rd[1]) ? 32'h1 : 32'h0));
  end

  // one access per call; starts and ends at a falling edge
  task automatic acc(input int s, input bit w, input bit r, input logic [5:0] ad, input logic [31:0] d);
    if (s == 0) begin a_wr = w; a_rd = r; a_addr = ad; a_wdata = d; end
    else        begin b_wr = w; b_rd = r; b_addr = ad; b_wdata = d; end
    @(negedge clk);
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic rd_chk(input int s, input logic [5:0] ad, input logic [31:0] exp, input string tag);
    acc(s, 0, 1, ad, 32'h0);
    check(tag, (s == 0) ? a_rdata : b_rdata, exp);
  endtask

  task automatic idle();
    acc(0, 0, 0, 6'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    phase = "R1";
    check("R1 a_irq", {31'h0, a_irq}, 32'h0);
    check("R1 b_core_rst", {31'h0, b_core_rst}, 32'h0);
    rd_chk(0, 6'h20, 32'h00F0_0000, "R1 A status");
    rd_chk(1, 6'h20, 32'h00F0_0000, "R1 B status");
    rd_chk(0, 6'h24, 32'h0, "R1 A control");

    phase = "R2";
    acc(0, 1, 0, 6'h04, 32'hDEAD_BEEF);
    rd_chk(1, 6'h20, 32'h02F0_0010, "R2/R12 B status full1");
    rd_chk(0, 6'h20, 32'h00D0_0000, "R2 A status empty1 cleared");
    phase = "R3";
    acc(0, 1, 0, 6'h04, 32'h1111_1111);
    rd_chk(0, 6'h04, 32'hDEAD_BEEF, "R3 A slot1 unchanged");
    phase = "R4";
    rd_chk(1, 6'h14, 32'hDEAD_BEEF, "R2 B incoming1 word");
    rd_chk(1, 6'h20, 32'h00F0_0000, "R4 B status full cleared");
    rd_chk(0, 6'h20, 32'h00F0_0000, "R4 A status empty again");

    phase = "R5";
    acc(0, 1, 0, 6'h24, 32'h0010_0000);
    idle();
    check("R5 a_irq on empty0", {31'h0, a_irq}, 32'h1);
    acc(0, 1, 0, 6'h24, 32'h0);
    idle();
    check("R5 a_irq off", {31'h0, a_irq}, 32'h0);

    phase = "R6";
    acc(0, 1, 0, 6'h24, 32'h0000_0005);
    rd_chk(0, 6'h20, 32'h00F0_0100, "R6 A flag copy in flight");
    rd_chk(1, 6'h20, 32'h00F0_0005, "R6 B sees flags");
    rd_chk(0, 6'h24, 32'h0000_0005, "R13 A control readback");
    acc(0, 1, 0, 6'h24, 32'h0);
    idle(); idle();

    phase = "R7";
    acc(1, 1, 0, 6'h24, 32'h0004_0000);
    idle();
    rd_chk(0, 6'h20, 32'h40F0_0010, "R7 A gi2 pending");
    rd_chk(1, 6'h24, 32'h0, "R7 B request self-cleared");
    acc(0, 1, 0, 6'h20, 32'h0);
    rd_chk(0, 6'h20, 32'h40F0_0010, "R7 write 0 leaves pending");
    acc(0, 1, 0, 6'h20, 32'h4000_0000);
    rd_chk(0, 6'h20, 32'h00F0_0000, "R7 write 1 clears");

    phase = "R8";
    acc(0, 1, 0, 6'h24, 32'h0000_0010);
    check("R8 b_core_rst", {31'h0, b_core_rst}, 32'h1);
    idle();
    rd_chk(0, 6'h20, 32'h00F0_0080, "R8 A status B in reset");

    phase = "R10";
    acc(1, 1, 0, 6'h00, 32'h1234_5678);
    rd_chk(1, 6'h20, 32'h0, "R10 B read dead");
    rd_chk(0, 6'h20, 32'h00F0_0080, "R10 B write ignored");

    phase = "R9";
    acc(0, 1, 0, 6'h24, 32'h0000_0040);
    check("R9 b_core_rst released", {31'h0, b_core_rst}, 32'h0);
    idle();
    rd_chk(0, 6'h20, 32'h80F0_0210, "R9 release pending and gi3");
    acc(0, 1, 0, 6'h20, 32'h8000_0200);
    rd_chk(0, 6'h20, 32'h00F0_0000, "R9 cleared");
    acc(0, 1, 0, 6'h24, 32'h0);

    phase = "R13";
    acc(0, 1, 0, 6'h00, 32'hCAFE_0001);
    rd_chk(0, 6'h00, 32'hCAFE_0001, "R13 slot readback");
    rd_chk(0, 6'h28, 32'h0, "R13 unmapped");
    check("R13 idle rdata", a_rdata, 32'h0);
    acc(1, 1, 0, 6'h24, 32'h0100_0000);
    idle();
    check("R5 b_irq on full0", {31'h0, b_irq}, 32'h1);
    rd_chk(1, 6'h10, 32'hCAFE_0001, "R2 B incoming0 word");
    idle();
    check("R5 b_irq off after read", {31'h0, b_irq}, 32'h0);
    acc(1, 1, 0, 6'h24, 32'h0);

    phase = "R11";
    acc(0, 1, 0, 6'h08, 32'h0000_0077);
    acc(1, 1, 0, 6'h24, 32'h0000_0003);
    acc(0, 1, 0, 6'h24, 32'h1000_0020);
    rd_chk(0, 6'h24, 32'h0, "R11 A control cleared");
    rd_chk(0, 6'h20, 32'h00F0_0000, "R11 A status reset");
    rd_chk(1, 6'h20, 32'h00F0_0000, "R11 B status reset");
    rd_chk(0, 6'h08, 32'h0, "R11 slot cleared");
    rd_chk(1, 6'h24, 32'h0, "R11 B control cleared");

    phase = "R12";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      a_wr = rv[0]; a_rd = rv[1] & ~rv[0];
      a_addr = {($urandom % 10), 2'b00};
      a_wdata = $urandom & ~32'h20;
      if (rv[8:4] == 0) a_wdata = a_wdata | 32'h20;
      b_wr = rv[2]; b_rd = rv[3] & ~rv[2];
      b_addr = {($urandom % 10), 2'b00};
      b_wdata = $urandom;
      @(negedge clk);
    end
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
    @(negedge clk);
    @(negedge clk);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule